// File: doc/BRIEF.md
# Latched One-of-Sixteen Address Decoder

This block turns a four-bit binary address into a one-of-sixteen selection on sixteen output lines. An address latch sits in front of the decoder and is controlled by a strobe. While the strobe is high, the latch is transparent and the outputs follow the live address in the same cycle. When the strobe is low, the latch holds the address it captured at the last rising clock edge that saw the strobe high. An inhibit input bypasses the latch and forces every line to its inactive level at once. The latched address is kept through inhibit.

A parameter picks the output polarity. In one variant the selected line is 1 and the rest are 0. In the other the selected line is 0 and the rest are 1. The latch has two named modes. In OPEN (strobe high) the decoder takes the live address and the register loads on every clock. In HELD (strobe low) the decoder takes the registered address. The transition OPEN to HELD happens when the strobe falls, and HELD to OPEN when it rises. Reset puts the latch in HELD with address 0. A typical use is steering a single serial bit, which arrives on inhibit, to one of sixteen destinations.

Top module: `latdec_top`

## Requirements
- R1: The address is binary, with bit 3 as the most significant bit. Address value k selects line k, so 4'b0101 selects line 5.
- R2: With ACTIVE_HIGH=1, the selected line is 1 and all other lines are 0.
- R3: With ACTIVE_HIGH=0, the selected line is 0 and all other lines are 1.
- R4: While strobe is 1 (OPEN), the outputs follow the live address in the same cycle, with no clock edge needed.
- R5: While strobe is 0 (HELD), the outputs reflect the address captured at the last rising clock edge with strobe 1. Address changes during HELD have no effect on the outputs.
- R6: While inhibit is 1, every line sits at its inactive level whatever the address. Inhibit acts without a clock edge and leaves the held address unchanged.
- R7: After reset, with strobe 0, the held address is 0 and line 0 is selected.
- R8: While inhibit is 0, exactly one line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address register |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | 1 makes the latch transparent, 0 holds it |
| addr_i | input | ADDR_W (4) | Binary address, bit 3 is the MSB |
| inhibit_i | input | 1 | 1 forces all lines inactive |
| sel_o | output | 2**ADDR_W (16) | Decoded lines, polarity set by ACTIVE_HIGH |

## Verification
The bench sweeps all sixteen addresses on two instances, one of each polarity. It repeats the sweep with inhibit set, and checks each result against a mask computed from a shift. It drops the strobe and then walks the address through all other values. A design that kept the latch transparent would let the outputs move during this walk. It asserts inhibit while holding and then releases it. A latch cleared by inhibit would come back at the wrong line. It also checks the output right after reset. A decoder with reversed bit order would select line 10 instead of line 5 for address 4'b0101.

// File: rtl/latdec_pkg.sv
package latdec_pkg;
    typedef enum logic {
        LM_HELD = 1'b0,
        LM_OPEN = 1'b1
    } latch_mode_e;
endpackage

// File: rtl/latdec_addr_latch.sv
module latdec_addr_latch
    import latdec_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    latch_mode_e       mode_q, mode_d;
    logic [ADDR_W-1:0] held_q;

    always_comb begin
        mode_d = strobe_i ? LM_OPEN : LM_HELD;
    end

    // state register: mode and captured address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= LM_HELD;
            held_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (mode_d == LM_OPEN) held_q <= addr_i;
        end
    end

    // output process: transparent path in OPEN, register in HELD
    always_comb begin
        unique case (mode_d)
            LM_OPEN: addr_o = addr_i;
            LM_HELD: addr_o = held_q;
            default: addr_o = held_q;
        endcase
    end

    // R5: a held address does not move while strobe stays low
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && mode_q == LM_HELD) |=> $stable(held_q));
    // R4: in OPEN the register captures the live address
    p_open_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (held_q == $past(addr_i) && mode_q == LM_OPEN));
endmodule

// File: rtl/latdec_onehot.sv
module latdec_onehot #(
    parameter int ADDR_W      = 4,
    parameter bit ACTIVE_HIGH = 1'b1,
    localparam int OUT_N      = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              inhibit_i,
    output logic [OUT_N-1:0]  lines_o
);
    logic [OUT_N-1:0] hot;

    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign hot[i] = !inhibit_i && (addr_i == ADDR_W'(i));
    end

    if (ACTIVE_HIGH) begin : g_high
        assign lines_o = hot;
    end else begin : g_low
        assign lines_o = ~hot;
    end
endmodule

// File: rtl/latdec_top.sv
module latdec_top #(
    parameter int ADDR_W      = 4,
    parameter bit ACTIVE_HIGH = 1'b1,
    localparam int OUT_N      = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              inhibit_i,
    output logic [OUT_N-1:0]  sel_o
);
    logic [ADDR_W-1:0] eff_addr;
    logic [OUT_N-1:0]  norm;

    latdec_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .addr_i   (addr_i),
        .addr_o   (eff_addr)
    );

    latdec_onehot #(.ADDR_W(ADDR_W), .ACTIVE_HIGH(ACTIVE_HIGH)) u_dec (
        .addr_i    (eff_addr),
        .inhibit_i (inhibit_i),
        .lines_o   (sel_o)
    );

    assign norm = ACTIVE_HIGH ? sel_o : ~sel_o;

    // R8: one active line when not inhibited
    p_single_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_i |-> $countones(norm) == 1);
    // R6: inhibit leaves every line inactive
    p_inhibit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |-> norm == '0);
    // R1: active line index equals the latch output
    p_index_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_i |-> norm[eff_addr]);
endmodule

// File: tb/latdec_top_tb.sv
module latdec_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic        inh = 1'b0;
    logic [15:0] sel_hi, sel_lo;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    latdec_top #(.ADDR_W(4), .ACTIVE_HIGH(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .addr_i(addr),
        .inhibit_i(inh), .sel_o(sel_hi));
    latdec_top #(.ADDR_W(4), .ACTIVE_HIGH(1'b0)) u_dut_lo (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .addr_i(addr),
        .inhibit_i(inh), .sel_o(sel_lo));

    function automatic logic [15:0] expect_hi(input int a, input bit inhibit);
        return inhibit ? 16'h0000 : (16'h0001 << a);
    endfunction

    task automatic check_both(input string req, input int a, input bit inhibit);
        logic [15:0] eh;
        eh = expect_hi(a, inhibit);
        checks++;
        if (sel_hi !== eh) begin
            errors++;
            $display("FAIL %s high: got %h expected %h", req, sel_hi, eh);
        end
        checks++;
        if (sel_lo !== ~eh) begin
            errors++;
            $display("FAIL %s low: got %h expected %h", req, sel_lo, ~eh);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check_both("R7 reset selects line 0", 0, 0);

        // R4 R1 R2 R3: transparent sweep
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            strobe = 1'b1; addr = 4'(a);
            #1 check_both("R4 transparent sweep", a, 0);
        end
        @(negedge clk); addr = 4'b0101;
        #1 check_both("R1 bit order 0101 -> line 5", 5, 0);

        // R6: inhibit over all addresses
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            inh = 1'b1; addr = 4'(a);
            #1 check_both("R6 inhibit sweep", a, 1);
        end
        inh = 1'b0;

        // R5: capture 9, then hold while address walks
        @(negedge clk); addr = 4'd9; strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        #1 check_both("R5 hold after fall", 9, 0);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk); addr = 4'(a);
            #1 check_both("R5 hold ignores address", 9, 0);
        end

        // R6: inhibit during hold keeps latched address
        @(negedge clk); inh = 1'b1; addr = 4'd2;
        #1 check_both("R6 inhibit while held", 2, 1);
        @(negedge clk); inh = 1'b0;
        #1 check_both("R6 release returns held line", 9, 0);

        // R2 R3: held sweep, one capture per address
        for (int a = 15; a >= 0; a--) begin
            @(negedge clk); strobe = 1'b1; addr = 4'(a);
            @(negedge clk); strobe = 1'b0; addr = 4'(15 - a);
            #1 check_both("R2 R3 held polarity sweep", a, 0);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule